// File: doc/BRIEF.md
# Hot-Plug and Receiver-Sense Deglitch Filter

This block cleans up two slow, asynchronous single-bit sense lines inside a display transmitter: the hot-plug detect line and the receiver-sense line. Each line is first brought into the clock domain through a two-flop synchronizer. It then passes through two filters in series. The first is a short glitch rejector that ignores any excursion lasting N cycles or fewer. The second is a long validity qualifier that ignores any level change lasting M×1024 cycles or fewer.

For each line the block drives a filtered level, plus a one-cycle rise pulse and a one-cycle fall pulse whenever that filtered level changes. The widths arrive on static configuration ports, with a separate pair for each line. A width of zero disables that filter stage. Software-facing registers, interrupt collection and the analog sensing itself live outside this block.

Top module: `hpdf_top`

## Requirements
- R1: Each raw input is synchronized by two flops. With both widths at 0, a change on a raw input held stable appears on its filtered level at the 4th rising clock edge after the edge at which it is first sampled.
- R2: With glitch width N, a synchronized excursion lasting N cycles or fewer is rejected and leaves the filtered level unchanged.
- R3: With glitch width N, a synchronized excursion lasting N+1 cycles or more passes the glitch stage. It reaches the glitch stage output after exactly N+1 cycles of difference.
- R4: With valid width M, the qualifier passes a change from the glitch stage only once that change has persisted for M×1024+1 consecutive cycles. Changes lasting M×1024 cycles or fewer are rejected.
- R5: The counter of each stage restarts from zero whenever that stage's input returns to the stage's current output value, so broken-up excursions do not add together.
- R6: The rise pulse (level goes 0 to 1) and the fall pulse (level goes 1 to 0) are each high for exactly one cycle, in the same cycle the filtered level changes. The two pulses are never high together.
- R7: The receiver-sense line uses its own 4-bit glitch width and 12-bit valid width. It is filtered independently of the hot-plug line.
- R8: While reset is asserted and right after it, every filtered level is 0 and no edge pulse is produced.
- R9: With all widths at 0, the filters add no rejection, and every synchronized change is passed on with a fixed latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_raw_i | input | 1 | Raw hot-plug sense line, asynchronous |
| rxs_raw_i | input | 1 | Raw receiver-sense line, asynchronous |
| hpd_glitch_w_i | input | 4 | Hot-plug glitch width N |
| hpd_valid_w_i | input | 12 | Hot-plug valid width M, in units of 1024 cycles |
| rxs_glitch_w_i | input | 4 | Receiver-sense glitch width N |
| rxs_valid_w_i | input | 12 | Receiver-sense valid width M, in units of 1024 cycles |
| hpd_level_o | output | 1 | Filtered hot-plug level |
| hpd_rise_o | output | 1 | One-cycle pulse when the filtered hot-plug level rises |
| hpd_fall_o | output | 1 | One-cycle pulse when the filtered hot-plug level falls |
| rxs_level_o | output | 1 | Filtered receiver-sense level |
| rxs_rise_o | output | 1 | One-cycle pulse when the filtered receiver-sense level rises |
| rxs_fall_o | output | 1 | One-cycle pulse when the filtered receiver-sense level falls |

## Verification
The lines are driven first with clean steps and zero widths, which pins down the fixed synchronizer and stage latency. Next come pulses one cycle shorter than, equal to, and one cycle longer than the glitch width, which separate an off-by-one in the rejection compare from a correct one. Broken pulses, where two short runs are separated by a single cycle back at the old level, show whether the counter restarts or accumulates. Long holds just under and just over M×1024 cycles test the scaling of the qualifier. Finally, the two lines are driven with different widths and unrelated pseudo-random patterns at the same time, which exposes any crossing of configuration or state between the channels.

// File: rtl/hpdf_pkg.sv
package hpdf_pkg;
  localparam int GLITCH_W = 4;
  localparam int VALID_W  = 12;
  localparam int SCALE_SH = 10;
  localparam int QUAL_CW  = VALID_W + SCALE_SH;
  localparam int NUM_CH   = 2;

  // qualification limit in cycles: M scaled by 1024
  function automatic logic [QUAL_CW-1:0] valid_limit(input logic [VALID_W-1:0] m);
    return {m, {SCALE_SH{1'b0}}};
  endfunction

  // a stage accepts the change when the run counter has reached the limit
  function automatic logic run_done(input logic [QUAL_CW-1:0] cnt,
                                    input logic [QUAL_CW-1:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/hpdf_sync.sv
module hpdf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hpdf_stage.sv
module hpdf_stage #(
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_i,
  input  logic [CW-1:0] limit_i,
  output logic          level_o,
  output logic          changed_o
);
  import hpdf_pkg::*;

  logic [CW-1:0] cnt;
  logic          differ;
  logic          accept;
  logic [QUAL_CW-1:0] cnt_ext, lim_ext;

  assign differ  = in_i != level_o;
  assign cnt_ext = QUAL_CW'(cnt);
  assign lim_ext = QUAL_CW'(limit_i);
  assign accept  = differ && run_done(cnt_ext, lim_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      level_o   <= 1'b0;
      changed_o <= 1'b0;
    end else begin
      changed_o <= accept;
      if (!differ) begin
        cnt <= '0;
      end else if (accept) begin
        cnt     <= '0;
        level_o <= in_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= limit_i) || !$stable(limit_i) || !$past(rst_n));

  assert_flip_needs_diff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> ($past(in_i) != $past(level_o)));

  assert_flip_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> ($past(cnt) >= $past(limit_i)));
endmodule

// File: rtl/hpdf_channel.sv
module hpdf_channel
  import hpdf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raw_i,
  input  logic [GLITCH_W-1:0] glitch_w_i,
  input  logic [VALID_W-1:0]  valid_w_i,
  output logic                level_o,
  output logic                rise_o,
  output logic                fall_o
);
  logic synced;
  logic gl_level, gl_changed;
  logic q_changed;
  logic [QUAL_CW-1:0] q_limit;

  assign q_limit = valid_limit(valid_w_i);

  hpdf_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_i), .sync_o(synced)
  );

  hpdf_stage #(.CW(GLITCH_W)) u_glitch (
    .clk(clk), .rst_n(rst_n), .in_i(synced), .limit_i(glitch_w_i),
    .level_o(gl_level), .changed_o(gl_changed)
  );

  hpdf_stage #(.CW(QUAL_CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .in_i(gl_level), .limit_i(q_limit),
    .level_o(level_o), .changed_o(q_changed)
  );

  assign rise_o = q_changed &&  level_o;
  assign fall_o = q_changed && !level_o;

  assert_glitch_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gl_changed |-> (gl_level != $past(gl_level)));

  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));

  assert_rise_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (level_o && !$past(level_o)));

  assert_fall_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!level_o && $past(level_o)));

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_o && !fall_o) |-> $stable(level_o));
endmodule

// File: rtl/hpdf_top.sv
module hpdf_top
  import hpdf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hpd_raw_i,
  input  logic                rxs_raw_i,
  input  logic [GLITCH_W-1:0] hpd_glitch_w_i,
  input  logic [VALID_W-1:0]  hpd_valid_w_i,
  input  logic [GLITCH_W-1:0] rxs_glitch_w_i,
  input  logic [VALID_W-1:0]  rxs_valid_w_i,
  output logic                hpd_level_o,
  output logic                hpd_rise_o,
  output logic                hpd_fall_o,
  output logic                rxs_level_o,
  output logic                rxs_rise_o,
  output logic                rxs_fall_o
);
  logic [NUM_CH-1:0]               raw_v, lvl_v, rise_v, fall_v;
  logic [NUM_CH-1:0][GLITCH_W-1:0] gw_v;
  logic [NUM_CH-1:0][VALID_W-1:0]  vw_v;

  assign raw_v = {rxs_raw_i, hpd_raw_i};
  assign gw_v  = {rxs_glitch_w_i, hpd_glitch_w_i};
  assign vw_v  = {rxs_valid_w_i, hpd_valid_w_i};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    hpdf_channel u_ch (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_v[ch]),
      .glitch_w_i(gw_v[ch]), .valid_w_i(vw_v[ch]),
      .level_o(lvl_v[ch]), .rise_o(rise_v[ch]), .fall_o(fall_v[ch])
    );
  end

  assign hpd_level_o = lvl_v[0];
  assign hpd_rise_o  = rise_v[0];
  assign hpd_fall_o  = fall_v[0];
  assign rxs_level_o = lvl_v[1];
  assign rxs_rise_o  = rise_v[1];
  assign rxs_fall_o  = fall_v[1];

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R8: assert (lvl_v == '0 && rise_v == '0 && fall_v == '0);
    end
  end
endmodule

// File: tb/sim_hpdf_top.sv
module sim_hpdf_top;
  localparam int CLK_P    = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hpd_raw = 1'b0, rxs_raw = 1'b0;
  logic [3:0]  hpd_gw = '0, rxs_gw = '0;
  logic [11:0] hpd_vw = '0, rxs_vw = '0;
  logic hpd_lvl, hpd_rise, hpd_fall, rxs_lvl, rxs_rise, rxs_fall;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int rise_seen [2];
  int fall_seen [2];
  string phase = "R8";

  // reference model state, index 0 hot-plug, 1 receiver sense
  int  m_s1 [2], m_s2 [2], m_g [2], m_v [2], m_grun [2], m_vrun [2];
  bit  m_rise [2], m_fall [2];

  always #(CLK_P/2) clk = ~clk;

  hpdf_top u0 (
    .clk(clk), .rst_n(rst_n), .hpd_raw_i(hpd_raw), .rxs_raw_i(rxs_raw),
    .hpd_glitch_w_i(hpd_gw), .hpd_valid_w_i(hpd_vw),
    .rxs_glitch_w_i(rxs_gw), .rxs_valid_w_i(rxs_vw),
    .hpd_level_o(hpd_lvl), .hpd_rise_o(hpd_rise), .hpd_fall_o(hpd_fall),
    .rxs_level_o(rxs_lvl), .rxs_rise_o(rxs_rise), .rxs_fall_o(rxs_fall)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_g[c] = 0; m_v[c] = 0;
        m_grun[c] = 0; m_vrun[c] = 0; m_rise[c] = 0; m_fall[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int glim, vlim, rawv;
        glim = (c == 0) ? int'(hpd_gw) : int'(rxs_gw);
        vlim = ((c == 0) ? int'(hpd_vw) : int'(rxs_vw)) * 1024;
        rawv = (c == 0) ? int'(hpd_raw) : int'(rxs_raw);
        m_rise[c] = 0; m_fall[c] = 0;
        if (m_g[c] != m_v[c]) begin
          m_vrun[c]++;
          if (m_vrun[c] > vlim) begin
            m_v[c] = m_g[c]; m_vrun[c] = 0;
            if (m_v[c] == 1) m_rise[c] = 1; else m_fall[c] = 1;
          end
        end else m_vrun[c] = 0;
        if (m_s2[c] != m_g[c]) begin
          m_grun[c]++;
          if (m_grun[c] > glim) begin m_g[c] = m_s2[c]; m_grun[c] = 0; end
        end else m_grun[c] = 0;
        m_s2[c] = m_s1[c];
        m_s1[c] = rawv;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (hpd_rise) rise_seen[0]++;
    if (hpd_fall) fall_seen[0]++;
    if (rxs_rise) rise_seen[1]++;
    if (rxs_fall) fall_seen[1]++;
    check({hpd_lvl, hpd_rise, hpd_fall} == {m_v[0] == 1, m_rise[0], m_fall[0]},
          {phase, " hpd"}, {hpd_lvl, hpd_rise, hpd_fall},
          {m_v[0] == 1, m_rise[0], m_fall[0]});
    check({rxs_lvl, rxs_rise, rxs_fall} == {m_v[1] == 1, m_rise[1], m_fall[1]},
          {phase, " rxs"}, {rxs_lvl, rxs_rise, rxs_fall},
          {m_v[1] == 1, m_rise[1], m_fall[1]});
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // caller sits at a negedge; values are held for n rising edges
  task automatic drive(input logic h, input logic r, input int n);
    hpd_raw = h; rxs_raw = r;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, r1;
    bit [15:0] lf;
    for (int c = 0; c < 2; c++) begin rise_seen[c] = 0; fall_seen[c] = 0; end
    repeat (3) @(negedge clk);
    check(hpd_lvl == 0 && rxs_lvl == 0, "R8 level in reset", hpd_lvl, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rise_seen[0] + rise_seen[1] + fall_seen[0] + fall_seen[1] == 0,
          "R8 no pulse after reset", rise_seen[0] + fall_seen[0], 0);

    // R1 / R9: latency with zero widths
    phase = "R1";
    hpd_raw = 1'b1;
    repeat (3) @(negedge clk);
    check(hpd_lvl == 0, "R1 level before 4th edge", hpd_lvl, 0);
    @(negedge clk);
    check(hpd_lvl == 1 && hpd_rise == 1, "R1 level at 4th edge", hpd_lvl, 1);
    @(negedge clk);
    check(hpd_rise == 0, "R6 rise lasts one cycle", hpd_rise, 0);
    phase = "R9";
    r0 = fall_seen[0];
    drive(0, 0, 1); drive(1, 0, 10);
    check(fall_seen[0] == r0 + 1, "R9 one-cycle dip passes", fall_seen[0], r0 + 1);
    drive(0, 0, 10);

    // R2 / R3: glitch width boundary
    phase = "R2";
    hpd_gw = 4'd5;
    r0 = rise_seen[0];
    drive(1, 0, 4); drive(0, 0, 12);
    drive(1, 0, 5); drive(0, 0, 12);
    check(rise_seen[0] == r0, "R2 pulse of N rejected", rise_seen[0], r0);
    phase = "R3";
    drive(1, 0, 6); drive(0, 0, 12);
    check(rise_seen[0] == r0 + 1, "R3 pulse of N+1 passes", rise_seen[0], r0 + 1);
    drive(1, 0, 9); drive(0, 0, 12);
    check(rise_seen[0] == r0 + 2, "R3 long pulse passes", rise_seen[0], r0 + 2);

    // R5: broken pulse does not accumulate
    phase = "R5";
    hpd_gw = 4'd4;
    r0 = rise_seen[0];
    drive(1, 0, 3); drive(0, 0, 1); drive(1, 0, 3); drive(0, 0, 12);
    check(rise_seen[0] == r0, "R5 counter restarts", rise_seen[0], r0);

    // R4: qualifier scaled by 1024
    phase = "R4";
    hpd_gw = 4'd0; hpd_vw = 12'd1;
    r0 = rise_seen[0];
    drive(1, 0, 1024); drive(0, 0, 20);
    check(rise_seen[0] == r0, "R4 hold of M*1024 rejected", rise_seen[0], r0);
    drive(1, 0, 1025); drive(1, 0, 10);
    check(rise_seen[0] == r0 + 1 && hpd_lvl == 1, "R4 hold of M*1024+1 passes",
          rise_seen[0], r0 + 1);
    hpd_vw = 12'd2;
    r0 = fall_seen[0];
    drive(0, 0, 2000); drive(1, 0, 10);
    check(fall_seen[0] == r0, "R4 short low rejected at M=2", fall_seen[0], r0);
    drive(0, 0, 2060);
    check(fall_seen[0] == r0 + 1, "R4 long low passes at M=2", fall_seen[0], r0 + 1);

    // R7: independent channels
    phase = "R7";
    hpd_vw = 12'd0; hpd_gw = 4'd2;
    rxs_gw = 4'd7; rxs_vw = 12'd0;
    r0 = rise_seen[0]; r1 = rise_seen[1];
    drive(1, 1, 5); drive(0, 0, 15);
    check(rise_seen[0] == r0 + 1, "R7 hpd passes at its width", rise_seen[0], r0 + 1);
    check(rise_seen[1] == r1, "R7 rxs rejects at its width", rise_seen[1], r1);
    r1 = fall_seen[1];
    rxs_vw = 12'd1;
    drive(0, 1, 1100); drive(0, 0, 1100);
    check(fall_seen[1] == r1 + 1 && rxs_lvl == 0, "R7 rxs own qualifier", fall_seen[1], r1 + 1);

    // mixed pseudo-random traffic on both lines
    phase = "R6";
    hpd_gw = 4'd3; rxs_gw = 4'd1; hpd_vw = 12'd0; rxs_vw = 12'd0;
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[0] ^ lf[5], lf[3] & lf[9], 1 + int'(lf[8:6]));
    end
    drive(0, 0, 30);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule